// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block gathers one-cycle event pulses from peripherals and external pins and holds a sticky request bit for each interrupt slot. Each pending request is qualified by its own enable bit and by a global interrupt-mask flag. The winning request is then offered to the CPU over a valid/ready handshake, which carries a vector index and the status word the CPU must push. Slots whose bit is set in the `SHARED_MASK` parameter take their events from one of two sources. A select register picks which source feeds the slot.

A software trap input (`brk_i`) is latched and offered ahead of every slot, whatever the mask flag says. Acceptance clears the winning request and sets the mask flag, so nested interrupts stay blocked until the handler issues a clear-flag command. Software reads and writes the request, enable and select registers through a simple register port, with address 0 for request, 1 for enable and 2 for select. Address 3 reads as zero.

Back-pressure rules for the offer channel:
- `ack_valid_o`, `ack_vec_o` and `ack_status_o` are combinational views of the current pending state. While `ack_ready_i` is low, they may change if a higher-priority request arrives or if the mask flag changes.
- A transfer happens only on a clock edge where `ack_valid_o` and `ack_ready_i` are both high.
- Holding `ack_ready_i` low never loses a request.

Top module: `intr_req_ctrl`

## Requirements
- R1: After reset the request, enable and select registers read 0, the mask flag `iflag_o` is 1 and `ack_valid_o` is 0.
- R2: A source pulse sets the slot's request bit on the next clock edge. The bit then stays 1 until that request is accepted or cleared by software.
- R3: A write to address 0 clears each request bit whose write-data bit is 0. A request bit whose write-data bit is 1 is left unchanged, so software can never set a request.
- R4: The enable register at address 1 stores any written value and reads it back. A pending request whose enable bit is 0 stays latched but is never offered.
- R5: While the mask flag is 1, no slot request is offered.
- R6: A latched trap is offered whatever the mask flag, with vector index `NUM_SLOTS` (8 by default), ahead of all slots. Accepting it clears it.
- R7: Among enabled pending slots with the mask flag at 0, the offered vector is the lowest slot index.
- R8: At a transfer, `ack_status_o` equals `cpu_status_i` with bit 2 replaced by the mask flag before acceptance. After the edge the mask flag is 1 and the accepted request bit is 0.
- R9: The commands act on the mask flag in this order of precedence: acceptance, then restore from bit 2 of `rti_status_i` (`flag_rti_i`), then set (`flag_set_i`), then clear (`flag_clr_i`).
- R10: Each select bit at address 2 exists only for shared slots and reads 0 elsewhere (default shared slots are 1 and 4). When a slot's select bit is 1, that slot follows `src_b_i`; when it is 0, the slot follows `src_a_i`. Unshared slots always follow `src_a_i`.
- R11: A source pulse in the same cycle as a software clear of its bit, or as acceptance of its bit, leaves the bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_a_i | input | NUM_SLOTS | Primary event pulses, one per slot |
| src_b_i | input | NUM_SLOTS | Alternate event pulses, used by shared slots only |
| brk_i | input | 1 | Software trap pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 request, 1 enable, 2 select |
| reg_wdata_i | input | NUM_SLOTS | Register write data |
| reg_rdata_o | output | NUM_SLOTS | Register read data for `reg_addr_i` |
| cpu_status_i | input | 8 | CPU status word, excluding the mask flag |
| flag_set_i | input | 1 | Set the mask flag |
| flag_clr_i | input | 1 | Clear the mask flag |
| flag_rti_i | input | 1 | Restore the mask flag from `rti_status_i` |
| rti_status_i | input | 8 | Status word popped at return; bit 2 is used |
| ack_valid_o | output | 1 | An interrupt is offered |
| ack_ready_i | input | 1 | CPU takes the offered interrupt |
| ack_vec_o | output | VEC_W | Offered vector index |
| ack_status_o | output | 8 | Status word to stack, with the pre-acceptance mask flag in bit 2 |
| iflag_o | output | 1 | Current mask flag |

## Verification
The arbiter is driven from a table of enable and pending patterns:
- single requests tell the slots apart;
- two or more requests expose the priority order;
- patterns in which every pending slot is disabled separate "latched" from "offered".

Directed sequences then cover the ordering cases:
- a trap raised under the mask;
- returns that restore 0 and 1;
- clear and set commands issued in the same cycle;
- shared slots switched between their two sources;
- events that collide with a software clear or with an acceptance.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    ADDR_REQ  = 2'd0,
    ADDR_EN   = 2'd1,
    ADDR_SEL  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  localparam int MASK_BIT = 2;
  localparam int STAT_W   = 8;
endpackage

// File: rtl/intc_src_mux.sv
module intc_src_mux #(
  parameter int                   N           = 8,
  parameter logic [N-1:0]         SHARED_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_wr_i,
  input  logic [N-1:0] sel_wdata_i,
  input  logic [N-1:0] src_a_i,
  input  logic [N-1:0] src_b_i,
  output logic [N-1:0] sel_q_o,
  output logic [N-1:0] hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    if (SHARED_MASK[g]) begin : g_shared
      logic sel_q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni)       sel_q <= 1'b0;
        else if (sel_wr_i) sel_q <= sel_wdata_i[g];
      end
      assign sel_q_o[g] = sel_q;
      assign hit_o[g]   = sel_q ? src_b_i[g] : src_a_i[g];
    end else begin : g_fixed
      assign sel_q_o[g] = 1'b0;
      assign hit_o[g]   = src_a_i[g];
    end
  end

  // R10
  sel_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr_i |=> (sel_q_o == ($past(sel_wdata_i) & SHARED_MASK)));
endmodule

// File: rtl/intc_req_bank.sv
module intc_req_bank #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_wdata_i,
  input  logic [N-1:0] acc_clr_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_wdata_i,
  output logic [N-1:0] req_q_o,
  output logic [N-1:0] en_q_o
);
  logic [N-1:0] sw_keep;
  logic [N-1:0] req_d;

  assign sw_keep = clr_wr_i ? clr_wdata_i : {N{1'b1}};
  assign req_d   = (req_q_o & sw_keep & ~acc_clr_i) | set_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      req_q_o <= '0;
      en_q_o  <= '0;
    end else begin
      req_q_o <= req_d;
      if (en_wr_i) en_q_o <= en_wdata_i;
    end
  end

  // R2
  req_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_wr_i && acc_clr_i == '0) |=> ((req_q_o & $past(req_q_o)) == $past(req_q_o)));
  // R3
  no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i |=> ((req_q_o & ~$past(req_q_o) & ~$past(set_i)) == '0));
  // R11
  pulse_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((req_q_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N     = 8,
  parameter int VEC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     cand_i,
  input  logic             trap_i,
  output logic             any_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [N-1:0]     onehot_o
);
  always_comb begin
    vec_o    = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        vec_o    = VEC_W'(i);
        onehot_o = N'(1) << i;
      end
    end
    if (trap_i) begin
      vec_o    = VEC_W'(N);
      onehot_o = '0;
    end
  end

  assign any_o = trap_i | (|cand_i);

  // R7
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_o && !trap_i) |-> (((cand_i & (onehot_o - N'(1))) == '0) && ((cand_i & onehot_o) != '0)));
  // R7
  single_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(onehot_o));
endmodule

// File: rtl/intc_flag.sv
module intc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic rti_i,
  input  logic rti_bit_i,
  input  logic set_i,
  input  logic clr_i,
  output logic iflag_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni)       iflag_o <= 1'b1;
    else if (accept_i) iflag_o <= 1'b1;
    else if (rti_i)    iflag_o <= rti_bit_i;
    else if (set_i)    iflag_o <= 1'b1;
    else if (clr_i)    iflag_o <= 1'b0;
  end

  // R8
  mask_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> iflag_o);
  // R9
  rti_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rti_i && !accept_i) |=> (iflag_o == $past(rti_bit_i)));
  // R9
  clr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i && !rti_i && !accept_i) |=> !iflag_o);
endmodule

// File: rtl/intr_req_ctrl.sv
module intr_req_ctrl #(
  parameter int                   NUM_SLOTS   = 8,
  parameter logic [NUM_SLOTS-1:0] SHARED_MASK = 8'b0001_0010,
  parameter int                   VEC_W       = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] src_a_i,
  input  logic [NUM_SLOTS-1:0] src_b_i,
  input  logic                 brk_i,
  input  logic                 reg_wr_i,
  input  logic [1:0]           reg_addr_i,
  input  logic [NUM_SLOTS-1:0] reg_wdata_i,
  output logic [NUM_SLOTS-1:0] reg_rdata_o,
  input  logic [7:0]           cpu_status_i,
  input  logic                 flag_set_i,
  input  logic                 flag_clr_i,
  input  logic                 flag_rti_i,
  input  logic [7:0]           rti_status_i,
  output logic                 ack_valid_o,
  input  logic                 ack_ready_i,
  output logic [VEC_W-1:0]     ack_vec_o,
  output logic [7:0]           ack_status_o,
  output logic                 iflag_o
);
  import intc_pkg::*;

  localparam int N = NUM_SLOTS;

  reg_addr_e    addr;
  logic [N-1:0] hit, sel_q, req_q, en_q, cand, onehot, acc_clr;
  logic         trap_q, fire, any;
  logic         unused_rti;

  assign addr       = reg_addr_e'(reg_addr_i);
  assign unused_rti = ^{rti_status_i[7:MASK_BIT+1], rti_status_i[MASK_BIT-1:0]};

  intc_src_mux #(.N(N), .SHARED_MASK(SHARED_MASK)) mux_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_wr_i   (reg_wr_i && addr == ADDR_SEL),
    .sel_wdata_i(reg_wdata_i),
    .src_a_i    (src_a_i),
    .src_b_i    (src_b_i),
    .sel_q_o    (sel_q),
    .hit_o      (hit)
  );

  intc_req_bank #(.N(N)) bank_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (hit),
    .clr_wr_i   (reg_wr_i && addr == ADDR_REQ),
    .clr_wdata_i(reg_wdata_i),
    .acc_clr_i  (acc_clr),
    .en_wr_i    (reg_wr_i && addr == ADDR_EN),
    .en_wdata_i (reg_wdata_i),
    .req_q_o    (req_q),
    .en_q_o     (en_q)
  );

  assign cand = req_q & en_q & {N{~iflag_o}};

  intc_prio #(.N(N), .VEC_W(VEC_W)) prio_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cand_i  (cand),
    .trap_i  (trap_q),
    .any_o   (any),
    .vec_o   (ack_vec_o),
    .onehot_o(onehot)
  );

  assign ack_valid_o = any;
  assign fire        = ack_valid_o && ack_ready_i;
  assign acc_clr     = (fire && !trap_q) ? onehot : '0;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) trap_q <= 1'b0;
    else         trap_q <= (trap_q && !fire) || brk_i;
  end

  intc_flag flag_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (fire),
    .rti_i    (flag_rti_i),
    .rti_bit_i(rti_status_i[MASK_BIT]),
    .set_i    (flag_set_i),
    .clr_i    (flag_clr_i),
    .iflag_o  (iflag_o)
  );

  always_comb begin
    ack_status_o           = cpu_status_i;
    ack_status_o[MASK_BIT] = iflag_o;
  end

  always_comb begin
    unique case (addr)
      ADDR_REQ: reg_rdata_o = req_q;
      ADDR_EN:  reg_rdata_o = en_q;
      ADDR_SEL: reg_rdata_o = sel_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  // R5
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iflag_o && !trap_q) |-> !ack_valid_o);
  // R6
  trap_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_q |-> (ack_valid_o && ack_vec_o == VEC_W'(N)));
  // R8
  accept_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !trap_q && (hit & onehot) == '0) |=> ((req_q & $past(onehot)) == '0));
endmodule

// File: tb/intr_req_ctrl_tb_top.sv
module intr_req_ctrl_tb_top;
  localparam int N = 8;
  localparam int VW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_a = '0, src_b = '0, wdata = '0;
  logic          brk = 1'b0, wr = 1'b0, fset = 1'b0, fclr = 1'b0, frti = 1'b0, ready = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [7:0]    cstat = 8'h00, rstat = 8'h00;
  logic [N-1:0]  rdata;
  logic          valid, iflag;
  logic [VW-1:0] vec;
  logic [7:0]    astat;
  int            checks = 0, failures = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  intr_req_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_a_i(src_a), .src_b_i(src_b), .brk_i(brk),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu_status_i(cstat), .flag_set_i(fset), .flag_clr_i(fclr), .flag_rti_i(frti),
    .rti_status_i(rstat), .ack_valid_o(valid), .ack_ready_i(ready), .ack_vec_o(vec),
    .ack_status_o(astat), .iflag_o(iflag)
  );

  // {enable[8], pulses[8], expected vector[4], expected valid[1]}
  localparam logic [20:0] PRIO_TBL [6] = '{
    {8'hFF, 8'h28, 4'd3, 1'b1},
    {8'hFF, 8'h80, 4'd7, 1'b1},
    {8'hF0, 8'h0F, 4'd0, 1'b0},
    {8'h0E, 8'h0C, 4'd2, 1'b1},
    {8'h01, 8'h01, 4'd0, 1'b1},
    {8'hC0, 8'hFF, 4'd6, 1'b1}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [N-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [N-1:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse_a(logic [N-1:0] v);
    src_a = v; tick(); src_a = '0;
  endtask

  task automatic pulse_b(logic [N-1:0] v);
    src_b = v; tick(); src_b = '0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd_chk("R1 req", 2'd0, 8'h00);
    rd_chk("R1 en", 2'd1, 8'h00);
    rd_chk("R1 sel", 2'd2, 8'h00);
    chk("R1 iflag", iflag, 1);
    chk("R1 valid", valid, 0);

    // R9 clear command
    fclr = 1'b1; tick(); fclr = 1'b0;
    chk("R9 clr", iflag, 0);

    // R7 R4 R2 priority table
    for (int k = 0; k < 6; k++) begin
      wr_reg(2'd0, 8'h00);
      wr_reg(2'd1, PRIO_TBL[k][20:13]);
      pulse_a(PRIO_TBL[k][12:5]);
      rd_chk("R4 en readback", 2'd1, PRIO_TBL[k][20:13]);
      rd_chk("R2 latched", 2'd0, PRIO_TBL[k][12:5]);
      chk("R7 R4 valid", valid, PRIO_TBL[k][0]);
      if (PRIO_TBL[k][0]) chk("R7 vec", vec, PRIO_TBL[k][4:1]);
    end

    // R2 held while not accepted
    repeat (3) tick();
    rd_chk("R2 hold", 2'd0, 8'hFF);

    // R3 write-1 ignored, write-0 clears
    wr_reg(2'd0, 8'hF0);
    rd_chk("R3 clear", 2'd0, 8'hF0);
    wr_reg(2'd0, 8'hFF);
    rd_chk("R3 no set", 2'd0, 8'hF0);

    // R8 handshake
    wr_reg(2'd1, 8'hFF);
    cstat = 8'hFB;
    #1;
    chk("R8 vec", vec, 4);
    chk("R8 status", astat, 8'hFB);
    ready = 1'b1; tick(); ready = 1'b0;
    chk("R8 iflag set", iflag, 1);
    rd_chk("R8 req cleared", 2'd0, 8'hE0);
    chk("R5 masked", valid, 0);

    // R6 trap under mask
    brk = 1'b1; tick(); brk = 1'b0;
    chk("R6 valid", valid, 1);
    chk("R6 vec", vec, 8);
    chk("R6 status", astat, 8'hFF);
    ready = 1'b1; tick(); ready = 1'b0;
    chk("R6 taken", valid, 0);

    // R9 return restores, precedence set over clear
    rstat = 8'h00; frti = 1'b1; tick(); frti = 1'b0;
    chk("R9 rti 0", iflag, 0);
    chk("R7 after rti", vec, 5);
    rstat = 8'h04; frti = 1'b1; fclr = 1'b1; tick(); frti = 1'b0; fclr = 1'b0;
    chk("R9 rti over clr", iflag, 1);
    chk("R5 masked again", valid, 0);
    fclr = 1'b1; tick();
    chk("R9 clr2", iflag, 0);
    fset = 1'b1; tick(); fset = 1'b0; fclr = 1'b0;
    chk("R9 set over clr", iflag, 1);

    // R10 source selection
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, 8'hFF);
    rd_chk("R10 sel mask", 2'd2, 8'h12);
    pulse_a(8'h02);
    rd_chk("R10 primary ignored", 2'd0, 8'h00);
    pulse_b(8'hFF);
    rd_chk("R10 alt only shared", 2'd0, 8'h12);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'h00);
    pulse_b(8'h10);
    rd_chk("R10 alt ignored", 2'd0, 8'h00);
    pulse_a(8'h10);
    rd_chk("R10 primary back", 2'd0, 8'h10);

    // R11 pulse vs software clear
    wr = 1'b1; addr = 2'd0; wdata = 8'h00; src_a = 8'h01;
    tick();
    wr = 1'b0; src_a = '0;
    rd_chk("R11 vs clear", 2'd0, 8'h01);

    // R11 pulse vs acceptance
    fclr = 1'b1; tick(); fclr = 1'b0;
    chk("R7 slot0", vec, 0);
    ready = 1'b1; src_a = 8'h01; tick(); ready = 1'b0; src_a = '0;
    rd_chk("R11 vs accept", 2'd0, 8'h01);
    chk("R8 flag after", iflag, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule